// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Multiplier

This block computes the Montgomery product of two K-bit operands, X·Y·2^(-K) mod N, for an odd modulus N whose top bit is set (2^(K-1) ≤ N < 2^K). Both X and Y must be smaller than N. A one-cycle `start` pulse latches the three operands. The block then walks through the bits of X one per clock, least significant first. For each bit it conditionally adds Y, then adds N whenever the running sum would otherwise be odd, and halves the result.

The running sum lives in carry-save form as a pair of vectors. Each iteration passes through two rows of 3:2 compressors, so no carry ripples during the loop. The quotient bit that decides whether N is added comes from a single XOR of the low bits. After the last iteration, one carry-propagate addition turns the pair back into binary, and a single conditional subtraction of N leaves the output fully reduced. A modular exponentiation controller would call this block once per squaring or multiplication.

Top module: `mont_mult`

## Requirements
- R1: While reset is asserted and after its release, `busy` is 0, `done` is 0 and `result` is 0 until the first operation completes.
- R2: A `start` sampled high at a clock edge while `busy` is 0 is accepted, and `busy` is 1 after that edge.
- R3: For a start accepted at edge e, `busy` stays 1 through edge e+K. At edge e+K+1 `busy` falls and `done` rises for exactly one cycle. `busy` and `done` are never 1 together.
- R4: In the cycle `done` is 1, `result` equals X·Y·2^(-K) mod N for the latched operands and is strictly smaller than N.
- R5: A `start` sampled while `busy` is 1 is ignored: neither the result nor the timing of the running operation changes.
- R6: `result` changes only at the edge that raises `done`, and holds its value between operations.
- R7: Operands are latched at the accepting edge. Later changes on `xIn`, `yIn` or `nIn` during the operation have no effect on the result.
- R8: A `start` sampled in the cycle where `done` is 1 is accepted and begins a new operation with the usual timing, while the finished result is presented in that same cycle.
- R9: Boundary operands give exact results: X = 0 yields 0, and the extreme moduli N = 2^K − 1 and N = 2^(K-1) + 1 with X and Y at N − 1 or 1 are reduced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| xIn | input | K | Multiplier operand X, scanned one bit per cycle |
| yIn | input | K | Multiplicand operand Y |
| nIn | input | K | Odd modulus N with its top bit set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | K | Fully reduced Montgomery product |

## Verification
The finishing of one product and the acceptance of the next can fall in the same cycle. The bench provokes this by watching for `done` at the falling edge and asserting `start` with fresh operands in that same cycle. Its cycle-accurate model then expects the old result to stay valid and the new operation to finish exactly K+1 edges later. A second overlap, a `start` landing in the middle of a running operation, is judged by requiring unchanged timing and a result that depends only on the first operands.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mont_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mont_state_t;

endpackage

// File: rtl/mont_csa_row.sv
module mont_csa_row #(
  parameter int W = 34
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] cIn,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carOut
);
  logic [W-1:0] majority;

  always_comb begin
    sumOut   = aIn ^ bIn ^ cIn;
    majority = (aIn & bIn) | (aIn & cIn) | (bIn & cIn);
    carOut   = majority << 1;
  end
endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int K = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output mont_ctl_t ctl,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  mont_state_t state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl.load   = (state == ST_IDLE) && start;
    ctl.step   = (state == ST_RUN);
    ctl.finish = (state == ST_FIN);
    busy       = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.finish;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_dp.sv
module mont_dp
  import mont_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mont_ctl_t    ctl,
  input  logic [K-1:0] xIn,
  input  logic [K-1:0] yIn,
  input  logic [K-1:0] nIn,
  output logic [K-1:0] result
);
  localparam int W = K + 2;

  logic [K-1:0] xReg, yReg, nReg;
  logic [W-1:0] sumVec, carVec;
  logic [W-1:0] addY, addN;
  logic [W-1:0] rowS [2];
  logic [W-1:0] rowC [2];
  logic [W-1:0] rowA [2];
  logic [W-1:0] rowB [2];
  logic [W-1:0] rowX [2];
  logic         qBit;
  logic [W-1:0] total, diff;
  logic [K-1:0] reduced;

  always_comb begin
    addY    = xReg[0] ? {2'b00, yReg} : '0;
    rowA[0] = sumVec;
    rowB[0] = carVec;
    rowX[0] = addY;
    // low bit of the true sum: the shifted carry row contributes 0
    qBit    = rowS[0][0];
    addN    = qBit ? {2'b00, nReg} : '0;
    rowA[1] = rowS[0];
    rowB[1] = rowC[0];
    rowX[1] = addN;
  end

  for (genvar g = 0; g < 2; g++) begin : g_row
    mont_csa_row #(.W(W)) u_row (
      .aIn    (rowA[g]),
      .bIn    (rowB[g]),
      .cIn    (rowX[g]),
      .sumOut (rowS[g]),
      .carOut (rowC[g])
    );
  end

  always_comb begin
    total   = sumVec + carVec;
    diff    = total - {2'b00, nReg};
    reduced = (total >= {2'b00, nReg}) ? diff[K-1:0] : total[K-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg   <= '0;
      yReg   <= '0;
      nReg   <= '0;
      sumVec <= '0;
      carVec <= '0;
      result <= '0;
    end else begin
      if (ctl.load) begin
        xReg   <= xIn;
        yReg   <= yIn;
        nReg   <= nIn;
        sumVec <= '0;
        carVec <= '0;
      end else if (ctl.step) begin
        xReg   <= xReg >> 1;
        sumVec <= rowS[1] >> 1;
        carVec <= rowC[1] >> 1;
      end
      if (ctl.finish) result <= reduced;
    end
  end
endmodule

// File: rtl/mont_mult.sv
module mont_mult
  import mont_pkg::*;
#(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [K-1:0] xIn,
  input  logic [K-1:0] yIn,
  input  logic [K-1:0] nIn,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] result
);
  mont_ctl_t ctl;

  mont_ctrl #(.K(K)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  mont_dp #(.K(K)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .xIn    (xIn),
    .yIn    (yIn),
    .nIn    (nIn),
    .result (result)
  );
endmodule

// File: rtl/mont_mult_chk.sv
module mont_mult_chk #(
  parameter int K = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [K-1:0] nIn,
  input logic         busy,
  input logic         done,
  input logic [K-1:0] result
);
  int           sinceStart;
  logic [K-1:0] nSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= 0;
      nSeen      <= '0;
    end else if (start && !busy) begin
      sinceStart <= 0;
      nSeen      <= nIn;
    end else if (busy) begin
      sinceStart <= sinceStart + 1;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == K + 1));

  p_reduced_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < nSeen));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);
endmodule

bind mont_mult mont_mult_chk #(.K(K)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .nIn    (nIn),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/mont_mult_test.sv
module mont_mult_test;
  localparam int K = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] xIn = '0, yIn = '0, nIn = '0;
  logic         busy, done;
  logic [K-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  mont_mult #(.K(K)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .xIn(xIn), .yIn(yIn), .nIn(nIn),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [K-1:0] montRef(logic [K-1:0] x, logic [K-1:0] y,
                                           logic [K-1:0] n);
    logic [2*K+1:0] acc;
    acc = {{(K+2){1'b0}}, x} * {{(K+2){1'b0}}, y};
    for (int i = 0; i < K; i++) begin
      if (acc[0]) acc = acc + {{(K+2){1'b0}}, n};
      acc = acc >> 1;
    end
    if (acc >= {{(K+2){1'b0}}, n}) acc = acc - {{(K+2){1'b0}}, n};
    return acc[K-1:0];
  endfunction

  // cycle-level reference model
  logic         mBusy, mDone;
  logic [K-1:0] mRes, mPend;
  int           mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mRes <= '0; mPend <= '0; mCnt <= 0;
    end else begin
      mDone <= 1'b0;
      if (!mBusy && start) begin
        mBusy <= 1'b1;
        mCnt  <= 0;
        mPend <= montRef(xIn, yIn, nIn);
      end else if (mBusy) begin
        if (mCnt == K) begin
          mBusy <= 1'b0;
          mDone <= 1'b1;
          mRes  <= mPend;
        end else begin
          mCnt <= mCnt + 1;
        end
      end
    end
  end

  task automatic check(string req, string what, logic [K-1:0] got, logic [K-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s (%s): got %h expected %h", req, what, phase, got, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check("R2/R5", "busy", K'(busy), K'(mBusy));
      check("R3/R8", "done", K'(done), K'(mDone));
      check(mDone ? "R4" : "R6", "result", result, mRes);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic launch(logic [K-1:0] x, logic [K-1:0] y, logic [K-1:0] n);
    xIn = x; yIn = y; nIn = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [K-1:0] randMod();
    return $urandom | {1'b1, {(K-2){1'b0}}, 1'b1};
  endfunction

  initial begin
    logic [K-1:0] n;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", K'(busy), '0);
    check("R1", "done in reset", K'(done), '0);
    check("R1", "result in reset", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "result after reset", result, '0);

    phase = "R4 random";
    for (int i = 0; i < 30; i++) begin
      n = randMod();
      launch($urandom % n, $urandom % n, n);
      repeat (K + 3) @(negedge clk);
    end

    phase = "R9 boundary";
    n = {K{1'b1}};
    launch('0, n - 1, n);           repeat (K + 3) @(negedge clk);
    launch(n - 1, n - 1, n);        repeat (K + 3) @(negedge clk);
    n = {1'b1, {(K-2){1'b0}}, 1'b1};
    launch(n - 1, n - 1, n);        repeat (K + 3) @(negedge clk);
    launch(1, 1, n);                repeat (K + 3) @(negedge clk);
    launch(n - 1, 1, n);            repeat (K + 3) @(negedge clk);

    phase = "R5 start while busy";
    for (int i = 0; i < 4; i++) begin
      n = randMod();
      launch($urandom % n, $urandom % n, n);
      repeat (3 + 5 * i) @(negedge clk);
      launch($urandom % n, $urandom % n, n);
      repeat (K + 3) @(negedge clk);
    end

    phase = "R7 operands change";
    for (int i = 0; i < 4; i++) begin
      n = randMod();
      launch($urandom % n, $urandom % n, n);
      for (int j = 0; j < K; j++) begin
        xIn = $urandom; yIn = $urandom; nIn = $urandom;
        @(negedge clk);
      end
      repeat (3) @(negedge clk);
    end

    phase = "R8 start with done";
    n = randMod();
    launch($urandom % n, $urandom % n, n);
    for (int i = 0; i < 5; i++) begin
      while (!done) @(negedge clk);
      n = randMod();
      launch($urandom % n, $urandom % n, n);
    end
    repeat (K + 4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule